// File: doc/BRIEF.md
# Segmented Write Protection with Access Code

This block decides whether each program or erase request may touch a register-modelled nonvolatile array. A movable pointer divides the address space in two. Addresses below the pointer are read-only. Addresses at or above it are freely writable while no access code is loaded. Once a code is loaded, they need an unlocked session. A one-shot override permits a single write below the pointer without moving it.

A command front-end hands the block one decoded command per cycle while chip-select is high. The commands are: load access code, unlock with code, write pointer, arm override, read pointer and program request. For each program request the block answers with a one-cycle grant or deny pulse. For a pointer read it returns the value with a valid pulse. Persistence is modelled by registers that only an explicit command changes.

An instruction error freezes the command interface until chip-select drops. Dropping chip-select also ends any unlocked session.

Top module: `seg_wprot`

## Requirements
- R1: After reset the block is unprotected (secure_o=0), not unlocked, shows no error, and the pointer reads 0.
- R2: A program request (op 5) gives exactly one of grant_o/deny_o one cycle after the command. An address below the pointer is denied unless an override is armed. While unprotected, an address at or above the pointer is granted.
- R3: Write-pointer (op 2) loads cmd_addr_i into the pointer, and the value holds until the next accepted write-pointer. Read-pointer (op 4) pulses rd_valid_o one cycle later, with rd_data_o holding the pointer.
- R4: Arm-override (op 3) permits exactly one granted program below the pointer. Programs at or above the pointer do not consume it.
- R5: Load-code (op 0) stores code_len_i bytes from code_i, with byte k in bits [8k+7:8k]. A length of 1 to CODE_BYTES sets secure_o. Length 0 clears it. A length above CODE_BYTES is rejected with an instruction error. An accepted load ends the unlocked session.
- R6: In secure mode, a program at or above the pointer is granted only while unlocked.
- R7: Unlock (op 1) sets enabled_o only if code_len_i equals the stored length and every stored byte matches. Input bytes beyond the length are ignored. Any mismatch clears enabled_o.
- R8: In secure mode without an unlocked session, load-code, write-pointer and arm-override do not execute and set instr_err_o.
- R9: instr_err_o is sticky, and while it is set every command is ignored. With cs_i low, commands are ignored and the next cycle has enabled_o=0 and instr_err_o=0.
- R10: Op codes 6 and 7 are invalid and set instr_err_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cs_i | input | 1 | Chip-select; low ends session and clears error |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_op_i | input | 3 | Command op code |
| cmd_addr_i | input | ADDR_W | Pointer value or program address |
| code_len_i | input | LEN_W | Access code length in bytes |
| code_i | input | 8*CODE_BYTES | Access code bytes, byte 0 in LSBs |
| grant_o | output | 1 | Program request granted (pulse) |
| deny_o | output | 1 | Program request denied (pulse) |
| rd_valid_o | output | 1 | Pointer read data valid (pulse) |
| rd_data_o | output | ADDR_W | Pointer value |
| secure_o | output | 1 | Access code loaded |
| enabled_o | output | 1 | Unlocked session active |
| instr_err_o | output | 1 | Sticky instruction error |

## Verification
The assertions check the following every cycle:
- grant and deny never pulse together, and every accepted program request is answered;
- the protection mode changes only on a load-code command;
- a read pulse or a session unlock appears only after its own command;
- the error flag sticks until chip-select drops;
- a locked pointer write always raises the error.

Only the bench scenarios can show the address-dependent outcomes. These are the split at the exact pointer boundary, the single use of an override, and code matching that distinguishes a wrong byte from a wrong length. They also include the pointer value that survives a rejected write.

// File: rtl/wp_pkg.sv
package wp_pkg;
  typedef enum logic [2:0] {
    OP_LOAD_CODE = 3'd0,
    OP_UNLOCK    = 3'd1,
    OP_WR_PTR    = 3'd2,
    OP_OVERRIDE  = 3'd3,
    OP_RD_PTR    = 3'd4,
    OP_PROGRAM   = 3'd5
  } wp_op_e;
endpackage

// File: rtl/wp_code_store.sv
module wp_code_store #(
  parameter int CODE_BYTES = 8,
  parameter int LEN_W      = $clog2(CODE_BYTES + 1)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    load_i,
  input  logic [LEN_W-1:0]        len_i,
  input  logic [8*CODE_BYTES-1:0] code_i,
  output logic                    secure_o,
  output logic                    match_o
);
  logic [LEN_W-1:0]        len_q;
  logic [8*CODE_BYTES-1:0] code_q;
  logic [CODE_BYTES-1:0]   byte_ok;

  for (genvar i = 0; i < CODE_BYTES; i++) begin : g_byte
    localparam logic [LEN_W-1:0] IDX = LEN_W'(i);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     code_q[8*i +: 8] <= '0;
      else if (load_i) code_q[8*i +: 8] <= (IDX < len_i) ? code_i[8*i +: 8] : 8'h00;
    end
    // bytes past the stored length never take part in the compare
    assign byte_ok[i] = (IDX >= len_q) || (code_q[8*i +: 8] == code_i[8*i +: 8]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     len_q <= '0;
    else if (load_i) len_q <= len_i;
  end

  assign secure_o = (len_q != '0);
  assign match_o  = (len_i == len_q) && (&byte_ok);
endmodule

// File: rtl/wp_ptr_reg.sv
module wp_ptr_reg #(
  parameter int ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic              arm_i,
  input  logic              consume_i,
  output logic [ADDR_W-1:0] ptr_o,
  output logic              armed_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   ptr_o <= '0;
    else if (wr_i) ptr_o <= wr_addr_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        armed_o <= 1'b0;
    else if (arm_i)     armed_o <= 1'b1;
    else if (consume_i) armed_o <= 1'b0;
  end
endmodule

// File: rtl/wp_gate.sv
module wp_gate #(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ADDR_W-1:0] ptr_i,
  input  logic              armed_i,
  input  logic              secure_i,
  input  logic              enabled_i,
  output logic              allow_o,
  output logic              use_override_o
);
  logic below;
  assign below          = (addr_i < ptr_i);
  assign allow_o        = below ? armed_i : (!secure_i || enabled_i);
  assign use_override_o = below && armed_i;
endmodule

// File: rtl/seg_wprot.sv
module seg_wprot #(
  parameter int CODE_BYTES = 8,
  parameter int ADDR_W     = 8,
  parameter int LEN_W      = $clog2(CODE_BYTES + 1)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    cs_i,
  input  logic                    cmd_valid_i,
  input  logic [2:0]              cmd_op_i,
  input  logic [ADDR_W-1:0]       cmd_addr_i,
  input  logic [LEN_W-1:0]        code_len_i,
  input  logic [8*CODE_BYTES-1:0] code_i,
  output logic                    grant_o,
  output logic                    deny_o,
  output logic                    rd_valid_o,
  output logic [ADDR_W-1:0]       rd_data_o,
  output logic                    secure_o,
  output logic                    enabled_o,
  output logic                    instr_err_o
);
  import wp_pkg::*;

  localparam logic [LEN_W-1:0] MAX_LEN = LEN_W'(CODE_BYTES);

  logic              en_q, err_q;
  logic              accept, auth, match;
  logic              do_load, do_unlock, do_wr, do_arm, do_rd, do_prog, raise_err;
  logic              allow, use_ovr;
  logic [ADDR_W-1:0] ptr;
  logic              armed;

  assign accept = cs_i && cmd_valid_i && !err_q;
  assign auth   = !secure_o || en_q;

  always_comb begin
    do_load   = 1'b0;
    do_unlock = 1'b0;
    do_wr     = 1'b0;
    do_arm    = 1'b0;
    do_rd     = 1'b0;
    do_prog   = 1'b0;
    raise_err = 1'b0;
    if (accept) begin
      case (cmd_op_i)
        OP_LOAD_CODE: if (auth && code_len_i <= MAX_LEN) do_load = 1'b1;
                      else raise_err = 1'b1;
        OP_UNLOCK:    do_unlock = 1'b1;
        OP_WR_PTR:    if (auth) do_wr = 1'b1; else raise_err = 1'b1;
        OP_OVERRIDE:  if (auth) do_arm = 1'b1; else raise_err = 1'b1;
        OP_RD_PTR:    do_rd = 1'b1;
        OP_PROGRAM:   do_prog = 1'b1;
        default:      raise_err = 1'b1;
      endcase
    end
  end

  wp_code_store #(.CODE_BYTES(CODE_BYTES), .LEN_W(LEN_W)) u_code (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (do_load),
    .len_i    (code_len_i),
    .code_i   (code_i),
    .secure_o (secure_o),
    .match_o  (match)
  );

  wp_ptr_reg #(.ADDR_W(ADDR_W)) u_ptr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (do_wr),
    .wr_addr_i (cmd_addr_i),
    .arm_i     (do_arm),
    .consume_i (do_prog && use_ovr),
    .ptr_o     (ptr),
    .armed_o   (armed)
  );

  wp_gate #(.ADDR_W(ADDR_W)) u_gate (
    .addr_i         (cmd_addr_i),
    .ptr_i          (ptr),
    .armed_i        (armed),
    .secure_i       (secure_o),
    .enabled_i      (en_q),
    .allow_o        (allow),
    .use_override_o (use_ovr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= 1'b0;
      err_q <= 1'b0;
    end else if (!cs_i) begin
      en_q  <= 1'b0;
      err_q <= 1'b0;
    end else begin
      if (raise_err) err_q <= 1'b1;
      if (do_unlock) en_q <= match;
      else if (do_load) en_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      grant_o    <= 1'b0;
      deny_o     <= 1'b0;
      rd_valid_o <= 1'b0;
      rd_data_o  <= '0;
    end else begin
      grant_o    <= do_prog && allow;
      deny_o     <= do_prog && !allow;
      rd_valid_o <= do_rd;
      if (do_rd) rd_data_o <= ptr;
    end
  end

  assign enabled_o   = en_q;
  assign instr_err_o = err_q;
endmodule

// File: rtl/wp_checker.sv
module wp_checker #(
  parameter int CODE_BYTES = 8,
  parameter int ADDR_W     = 8,
  parameter int LEN_W      = $clog2(CODE_BYTES + 1)
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    cs_i,
  input logic                    cmd_valid_i,
  input logic [2:0]              cmd_op_i,
  input logic [ADDR_W-1:0]       cmd_addr_i,
  input logic [LEN_W-1:0]        code_len_i,
  input logic [8*CODE_BYTES-1:0] code_i,
  input logic                    grant_o,
  input logic                    deny_o,
  input logic                    rd_valid_o,
  input logic [ADDR_W-1:0]       rd_data_o,
  input logic                    secure_o,
  input logic                    enabled_o,
  input logic                    instr_err_o
);
  logic live;
  assign live = cs_i && cmd_valid_i && !instr_err_o;

  assert_grant_deny_excl_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(grant_o && deny_o));

  assert_prog_answered_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live && cmd_op_i == 3'd5) |=> (grant_o || deny_o));

  assert_rd_only_on_cmd_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(live && cmd_op_i == 3'd4) |=> !rd_valid_o);

  assert_mode_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(live && cmd_op_i == 3'd0) |=> $stable(secure_o));

  assert_unlock_only_on_cmd_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(live && cmd_op_i == 3'd1) |=> !$rose(enabled_o));

  assert_locked_ptr_err_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live && secure_o && !enabled_o && cmd_op_i == 3'd2) |=> instr_err_o);

  assert_err_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_i && instr_err_o) |=> instr_err_o);

  assert_cs_drop_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_i |=> (!enabled_o && !instr_err_o));

  assert_bad_op_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live && cmd_op_i >= 3'd6) |=> instr_err_o);
endmodule

bind seg_wprot wp_checker #(.CODE_BYTES(CODE_BYTES), .ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_chk (.*);

// File: tb/sim_seg_wprot.sv
module sim_seg_wprot;
  localparam int CB = 8;
  localparam int AW = 8;
  localparam int LW = $clog2(CB + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cs = 1'b1;
  logic          cmd_valid = 1'b0;
  logic [2:0]    cmd_op = '0;
  logic [AW-1:0] cmd_addr = '0;
  logic [LW-1:0] code_len = '0;
  logic [8*CB-1:0] code = '0;
  logic          grant, deny, rd_valid, secure, enabled, instr_err;
  logic [AW-1:0] rd_data;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  seg_wprot #(.CODE_BYTES(CB), .ADDR_W(AW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .cs_i(cs), .cmd_valid_i(cmd_valid),
    .cmd_op_i(cmd_op), .cmd_addr_i(cmd_addr), .code_len_i(code_len), .code_i(code),
    .grant_o(grant), .deny_o(deny), .rd_valid_o(rd_valid), .rd_data_o(rd_data),
    .secure_o(secure), .enabled_o(enabled), .instr_err_o(instr_err)
  );

  localparam logic [2:0] LOAD = 3'd0, UNLK = 3'd1, WPTR = 3'd2, OVR = 3'd3,
                         RPTR = 3'd4, PROG = 3'd5;
  localparam logic [63:0] C3   = 64'h0000_0000_00CC_BBAA;
  localparam logic [63:0] C8   = 64'h0102_0304_0506_0708;

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one command cycle; outputs are sampled at the following negedge
  task automatic cmd(logic [2:0] op, logic [7:0] a = 8'h00, logic [3:0] l = 4'd0,
                     logic [63:0] c = 64'h0);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; code_len = l; code = c;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic cs_pulse();
    @(negedge clk); cs = 1'b0;
    @(negedge clk); cs = 1'b1;
  endtask

  task automatic prog_expect(string req, logic [7:0] a, bit g);
    cmd(PROG, a);
    check(req, {grant, deny}, {g, !g});
  endtask

  task automatic rd_expect(string req, logic [7:0] v);
    cmd(RPTR);
    check(req, {rd_valid, rd_data}, {1'b1, v});
  endtask

  task automatic t_reset();
    check("R1 secure", secure, 0);
    check("R1 enabled", enabled, 0);
    check("R1 err", instr_err, 0);
    check("R1 pulses", {grant, deny, rd_valid}, 0);
    rd_expect("R1 ptr", 8'h00);
    prog_expect("R1 program addr0", 8'h00, 1);
  endtask

  task automatic t_unprotected_split();
    cmd(WPTR, 8'h40);
    rd_expect("R3 ptr load", 8'h40);
    prog_expect("R2 below", 8'h3F, 0);
    prog_expect("R2 boundary", 8'h40, 1);
    prog_expect("R2 top", 8'hFF, 1);
    rd_expect("R3 ptr hold", 8'h40);
  endtask

  task automatic t_override();
    cmd(OVR);
    prog_expect("R4 above keeps arm", 8'h80, 1);
    prog_expect("R4 one write below", 8'h10, 1);
    prog_expect("R4 consumed", 8'h10, 0);
  endtask

  task automatic t_secure_locked();
    cmd(LOAD, 8'h00, 4'd3, C3);
    check("R5 secure set", secure, 1);
    prog_expect("R6 locked above", 8'h80, 0);
    cmd(WPTR, 8'h20);
    check("R8 locked wptr err", instr_err, 1);
    cmd(RPTR);
    check("R9 ignored while err", rd_valid, 0);
    cs_pulse();
    check("R9 err cleared", instr_err, 0);
    rd_expect("R8 ptr unchanged", 8'h40);
    cmd(OVR);
    check("R8 locked override err", instr_err, 1);
    cs_pulse();
    prog_expect("R8 override not armed", 8'h10, 0);
    cmd(LOAD, 8'h00, 4'd0, 64'h0);
    check("R8 locked load err", instr_err, 1);
    cs_pulse();
    check("R8 still secure", secure, 1);
  endtask

  task automatic t_unlock();
    cmd(UNLK, 8'h00, 4'd3, 64'h0000_0000_00CC_BBAB);
    check("R7 wrong byte", enabled, 0);
    cmd(UNLK, 8'h00, 4'd4, 64'h0000_0000_11CC_BBAA);
    check("R7 wrong length", enabled, 0);
    cmd(UNLK, 8'h00, 4'd3, 64'hFFFF_FFFF_FFCC_BBAA);
    check("R7 match ignores upper bytes", enabled, 1);
    cmd(UNLK, 8'h00, 4'd3, 64'h0000_0000_00CC_BBAB);
    check("R7 mismatch clears", enabled, 0);
    cmd(UNLK, 8'h00, 4'd3, C3);
    check("R7 relock", enabled, 1);
    cmd(WPTR, 8'h20);
    check("R8 unlocked no err", instr_err, 0);
    rd_expect("R3 secure ptr load", 8'h20);
    prog_expect("R6 unlocked above", 8'h80, 1);
    prog_expect("R2 secure below", 8'h10, 0);
    cmd(OVR);
    prog_expect("R4 secure override", 8'h10, 1);
    cs_pulse();
    check("R9 cs ends session", enabled, 0);
    prog_expect("R6 relocked above", 8'h25, 0);
  endtask

  task automatic t_clear_code();
    cmd(UNLK, 8'h00, 4'd3, C3);
    cmd(LOAD, 8'h00, 4'd0, 64'h0);
    check("R5 zero length clears", secure, 0);
    check("R5 load ends session", enabled, 0);
    prog_expect("R2 unprotected again", 8'h80, 1);
  endtask

  task automatic t_limits();
    cmd(LOAD, 8'h00, 4'd9, C8);
    check("R5 too long err", instr_err, 1);
    check("R5 too long not loaded", secure, 0);
    cs_pulse();
    cmd(3'd7);
    check("R10 bad op err", instr_err, 1);
    cs_pulse();
    cmd(3'd6);
    check("R10 bad op 6 err", instr_err, 1);
    cs_pulse();
    cmd(LOAD, 8'h00, 4'd8, C8);
    check("R5 eight bytes", secure, 1);
    cmd(UNLK, 8'h00, 4'd8, C8);
    check("R7 eight byte match", enabled, 1);
    cmd(UNLK, 8'h00, 4'd8, C8 ^ 64'h8000_0000_0000_0000);
    check("R7 top byte mismatch", enabled, 0);
    @(negedge clk); cs = 1'b0;
    cmd(RPTR);
    check("R9 cs low ignored", rd_valid, 0);
    cs = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_unprotected_split();
    t_override();
    t_secure_locked();
    t_unlock();
    t_clear_code();
    t_limits();
    repeat (2) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule